// File: doc/BRIEF.md
# Commutation Output Pattern Sequencer

This block routes one externally generated PWM waveform onto six output pins following a programmed list of output patterns, in the manner used to commutate a brushless motor. Twelve pattern entries are held in a buffer. When the selected trigger condition occurs, the entry named by an internal pointer is copied into an active pattern register. For each pin, that register decides whether the pin carries the PWM or sits at a fixed level. The pointer then steps on, wrapping at a programmable sequence length.

Triggers come from three places: a software write to entry 0, an underflow pulse from an external delay timer, or a change on a 3-bit rotor-position input. A combined mode lets a position change start the delay timer, so that the switch happens only when the timer underflows. Pattern changes wait for the next rising edge of the PWM, so a pin never sees a shortened pulse. An emergency stop input drives every pin low at once. The stop stays in force until software clears it.

Top module: `commutation_seq`

## Requirements
- R1: After reset, all six outputs are 0, the entry pointer is 0, the active pattern is all zeros and the timer-start output is 0.
- R2: A pattern is 12 bits wide. Bit 6+i is the PWM enable for output i and bit i is its static level. With enable 1, output i follows the PWM input; with enable 0, it equals the level bit.
- R3: In mode 0 (software), a write to entry 0 requests a transfer of entry 0, and the pointer does not move. A write to any other entry requests nothing.
- R4: In mode 1 (timer), an underflow pulse requests a transfer of the entry at the pointer. Changes on the position input are ignored.
- R5: In mode 2 (position), a change of the 3-bit position input, seen through a two-flop synchroniser, requests a transfer. Underflow pulses are ignored.
- R6: In mode 3 (delayed), a position change emits a one-cycle timer-start pulse and requests no transfer. A later underflow requests the transfer. The timer-start output is high only in this mode.
- R7: In mode 4 (either), both an underflow pulse and a position change request a transfer.
- R8: A requested transfer takes effect only on the clock edge at which the PWM input is sampled high after being sampled low. Several requests made before one such edge give a single transfer.
- R9: In every mode except mode 0, each transfer moves the pointer to the next entry. After entry L-1, where L is the sequence length, the pointer returns to 0. A length of 0 or more than 12 acts as 12. A pointer-clear strobe sets the pointer to 0.
- R10: While the stop input is high, all outputs are 0 in the same cycle. After the stop input falls, the outputs stay 0 until a stop-clear strobe is sampled with the stop input low.
- R11: Mode codes 5, 6 and 7 request no transfer from any source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwmIn | input | 1 | PWM waveform to be steered (synchronous to clk) |
| sensorIn | input | 3 | Rotor-position inputs (asynchronous) |
| uflowIn | input | 1 | Delay-timer underflow pulse |
| trigMode | input | 3 | Trigger source select, codes 0 to 7 |
| seqLen | input | 4 | Number of entries in the commutation cycle |
| wrEn | input | 1 | Pattern buffer write strobe |
| wrIdx | input | 4 | Entry index to write |
| wrData | input | 12 | Pattern to write (enables high, levels low) |
| ptrClr | input | 1 | Return the entry pointer to 0 |
| shutdownIn | input | 1 | Emergency stop |
| sdClr | input | 1 | Release a latched emergency stop |
| optOut | output | 6 | Steered output pins |
| patOut | output | 12 | Active pattern register |
| ptrOut | output | 4 | Current entry pointer |
| timerStart | output | 1 | Start pulse for the external delay timer |

## Verification
Fixed patterns with distinct enable and level mixes are applied in each of the trigger modes. Each trigger source is fired in turn, so that the bench can tell which source a mode obeys and which it ignores. The bench raises requests while the PWM is held low and checks that the active pattern holds until the PWM rises. Bursts of requests before a single rise show that they merge into one transfer. A short sequence length, plus random patterns run over a random length, test the pointer wrap. The stop input is checked against a pattern with static-high levels, which shows both the immediate force and the latched hold.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
  typedef enum logic [2:0] {
    TRIG_SW    = 3'd0,
    TRIG_UF    = 3'd1,
    TRIG_SENSE = 3'd2,
    TRIG_DELAY = 3'd3,
    TRIG_ANY   = 3'd4
  } trigMode_t;

  typedef struct packed {
    logic load;
    logic forceOff;
  } seqStrobe_t;
endpackage

// File: rtl/cseq_ctrl.sv
module cseq_ctrl
  import cseq_pkg::*;
#(
  parameter int NUM_ENTRY = 12,
  parameter int SENSE_W   = 3,
  parameter int IDX_W     = 4,
  parameter int LEN_W     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pwmIn,
  input  logic [SENSE_W-1:0] sensorIn,
  input  logic               uflowIn,
  input  logic [2:0]         trigMode,
  input  logic [LEN_W-1:0]   seqLen,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic               ptrClr,
  input  logic               shutdownIn,
  input  logic               sdClr,
  output seqStrobe_t         strobe,
  output logic [IDX_W-1:0]   loadIdx,
  output logic [IDX_W-1:0]   ptrOut,
  output logic               timerStart
);
  trigMode_t mode;
  assign mode = trigMode_t'(trigMode);

  logic [SENSE_W-1:0] senseMeta, senseSync, senseLast;
  logic senseEvt, swEvt, trigReq, pending, pwmLast, pwmRise, sdLat;
  logic [IDX_W-1:0] ptr, nextPtr;
  int wrapLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      senseMeta <= '0;
      senseSync <= '0;
      senseLast <= '0;
      pwmLast   <= 1'b0;
    end else begin
      senseMeta <= sensorIn;
      senseSync <= senseMeta;
      senseLast <= senseSync;
      pwmLast   <= pwmIn;
    end
  end

  assign senseEvt = (senseSync != senseLast);
  assign swEvt    = wrEn && (wrIdx == '0);
  assign pwmRise  = pwmIn && !pwmLast;

  always_comb begin
    unique case (mode)
      TRIG_SW:    trigReq = swEvt;
      TRIG_UF:    trigReq = uflowIn;
      TRIG_SENSE: trigReq = senseEvt;
      TRIG_DELAY: trigReq = uflowIn;
      TRIG_ANY:   trigReq = uflowIn || senseEvt;
      default:    trigReq = 1'b0;
    endcase
  end

  assign timerStart = (mode == TRIG_DELAY) && senseEvt;

  always_comb begin
    if (int'(seqLen) == 0 || int'(seqLen) > NUM_ENTRY) wrapLen = NUM_ENTRY;
    else wrapLen = int'(seqLen);
    if (int'(ptr) + 1 >= wrapLen) nextPtr = '0;
    else nextPtr = ptr + 1'b1;
  end

  assign strobe.load     = pending && pwmRise;
  assign strobe.forceOff = shutdownIn || sdLat;
  assign loadIdx         = (mode == TRIG_SW) ? '0 : ptr;
  assign ptrOut          = ptr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      ptr     <= '0;
      sdLat   <= 1'b0;
    end else begin
      if (trigReq) pending <= 1'b1;
      else if (strobe.load) pending <= 1'b0;

      if (ptrClr) ptr <= '0;
      else if (strobe.load && mode != TRIG_SW) ptr <= nextPtr;

      if (shutdownIn) sdLat <= 1'b1;
      else if (sdClr) sdLat <= 1'b0;
    end
  end
endmodule

// File: rtl/cseq_datapath.sv
module cseq_datapath
  import cseq_pkg::*;
#(
  parameter int NUM_OUT   = 6,
  parameter int NUM_ENTRY = 12,
  parameter int IDX_W     = 4,
  localparam int PAT_W    = 2 * NUM_OUT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pwmIn,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [PAT_W-1:0]   wrData,
  input  seqStrobe_t         strobe,
  input  logic [IDX_W-1:0]   loadIdx,
  output logic [NUM_OUT-1:0] optOut,
  output logic [PAT_W-1:0]   patOut
);
  logic [PAT_W-1:0] patBuf [NUM_ENTRY];
  logic [PAT_W-1:0] active;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < NUM_ENTRY; e++) patBuf[e] <= '0;
    end else if (wrEn) begin
      for (int e = 0; e < NUM_ENTRY; e++)
        if (int'(wrIdx) == e) patBuf[e] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) active <= '0;
    else if (strobe.load && int'(loadIdx) < NUM_ENTRY) active <= patBuf[loadIdx];
  end

  assign patOut = active;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_pin
    always_comb begin
      if (strobe.forceOff) optOut[i] = 1'b0;
      else if (active[NUM_OUT+i]) optOut[i] = pwmIn;
      else optOut[i] = active[i];
    end
  end
endmodule

// File: rtl/commutation_seq.sv
module commutation_seq
  import cseq_pkg::*;
#(
  parameter int NUM_OUT   = 6,
  parameter int NUM_ENTRY = 12,
  parameter int SENSE_W   = 3,
  localparam int IDX_W    = $clog2(NUM_ENTRY),
  localparam int LEN_W    = $clog2(NUM_ENTRY + 1),
  localparam int PAT_W    = 2 * NUM_OUT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pwmIn,
  input  logic [SENSE_W-1:0] sensorIn,
  input  logic               uflowIn,
  input  logic [2:0]         trigMode,
  input  logic [LEN_W-1:0]   seqLen,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [PAT_W-1:0]   wrData,
  input  logic               ptrClr,
  input  logic               shutdownIn,
  input  logic               sdClr,
  output logic [NUM_OUT-1:0] optOut,
  output logic [PAT_W-1:0]   patOut,
  output logic [IDX_W-1:0]   ptrOut,
  output logic               timerStart
);
  seqStrobe_t strobe;
  logic [IDX_W-1:0] loadIdx;

  cseq_ctrl #(
    .NUM_ENTRY(NUM_ENTRY), .SENSE_W(SENSE_W), .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .sensorIn(sensorIn),
    .uflowIn(uflowIn), .trigMode(trigMode), .seqLen(seqLen),
    .wrEn(wrEn), .wrIdx(wrIdx), .ptrClr(ptrClr),
    .shutdownIn(shutdownIn), .sdClr(sdClr),
    .strobe(strobe), .loadIdx(loadIdx), .ptrOut(ptrOut),
    .timerStart(timerStart)
  );

  cseq_datapath #(
    .NUM_OUT(NUM_OUT), .NUM_ENTRY(NUM_ENTRY), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrData(wrData), .strobe(strobe), .loadIdx(loadIdx),
    .optOut(optOut), .patOut(patOut)
  );
endmodule

// File: rtl/cseq_checker.sv
module cseq_checker #(
  parameter int NUM_OUT   = 6,
  parameter int NUM_ENTRY = 12,
  parameter int IDX_W     = 4,
  parameter int PAT_W     = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               pwmIn,
  input logic [2:0]         trigMode,
  input logic               ptrClr,
  input logic               shutdownIn,
  input logic [NUM_OUT-1:0] optOut,
  input logic [PAT_W-1:0]   patOut,
  input logic [IDX_W-1:0]   ptrOut,
  input logic               timerStart
);
  a_r10_stop_now: assert property (@(posedge clk) disable iff (!rstN)
    shutdownIn |-> (optOut == '0));

  a_r10_stop_held: assert property (@(posedge clk) disable iff (!rstN)
    ($past(shutdownIn) && $past(rstN)) |-> (optOut == '0));

  a_r8_pattern_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(pwmIn && !$past(pwmIn)) |=> $stable(patOut));

  a_r9_ptr_in_range: assert property (@(posedge clk) disable iff (!rstN)
    int'(ptrOut) < NUM_ENTRY);

  a_r9_ptr_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!(pwmIn && !$past(pwmIn)) && !ptrClr) |=> $stable(ptrOut));

  a_r6_start_only_delayed: assert property (@(posedge clk) disable iff (!rstN)
    timerStart |-> (trigMode == 3'd3));

  a_r3_sw_keeps_ptr: assert property (@(posedge clk) disable iff (!rstN)
    (trigMode == 3'd0 && !ptrClr) |=> $stable(ptrOut));
endmodule

bind commutation_seq cseq_checker #(
  .NUM_OUT(NUM_OUT), .NUM_ENTRY(NUM_ENTRY), .IDX_W(IDX_W), .PAT_W(PAT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .trigMode(trigMode),
  .ptrClr(ptrClr), .shutdownIn(shutdownIn), .optOut(optOut),
  .patOut(patOut), .ptrOut(ptrOut), .timerStart(timerStart)
);

// File: tb/commutation_seq_bench.sv
`timescale 1ns/1ps
module commutation_seq_bench;
  logic clk = 1'b0;
  logic rstN, pwmIn, uflowIn, wrEn, ptrClr, shutdownIn, sdClr;
  logic [2:0] sensorIn, trigMode;
  logic [3:0] seqLen, wrIdx;
  logic [11:0] wrData;
  logic [5:0] optOut;
  logic [11:0] patOut;
  logic [3:0] ptrOut;
  logic timerStart;

  always #2.5 clk = ~clk;

  commutation_seq u_commutation_seq (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .sensorIn(sensorIn),
    .uflowIn(uflowIn), .trigMode(trigMode), .seqLen(seqLen),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .ptrClr(ptrClr),
    .shutdownIn(shutdownIn), .sdClr(sdClr), .optOut(optOut),
    .patOut(patOut), .ptrOut(ptrOut), .timerStart(timerStart)
  );

  int nChecks = 0;
  int nFails  = 0;
  int startCnt = 0;
  logic [11:0] bufM [12];
  logic [11:0] actM;
  int ptrM;
  bit pendM, offM;

  always @(posedge clk) if (rstN && timerStart) startCnt++;

  function automatic logic [5:0] expOut(logic [11:0] p, logic pw, bit off);
    logic [5:0] o;
    for (int i = 0; i < 6; i++) o[i] = off ? 1'b0 : (p[6+i] ? pw : p[i]);
    return o;
  endfunction

  function automatic int wrapOf(logic [3:0] l);
    return (l == 0 || l > 12) ? 12 : int'(l);
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chkState(string tag);
    check(tag, patOut, actM, "pattern");
    check(tag, ptrOut, ptrM, "pointer");
    check(tag, optOut, expOut(actM, pwmIn, offM), "outputs");
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic finishUp;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  task automatic wr(int idx, logic [11:0] d);
    wrEn = 1; wrIdx = 4'(idx); wrData = d; tick; wrEn = 0;
    bufM[idx] = d;
    if (trigMode == 0 && idx == 0) pendM = 1;
  endtask

  task automatic uf;
    uflowIn = 1; tick; uflowIn = 0; tick;
    if (trigMode == 1 || trigMode == 3 || trigMode == 4) pendM = 1;
  endtask

  task automatic senseTo(logic [2:0] v);
    sensorIn = v; repeat (4) tick;
    if (trigMode == 2 || trigMode == 4) pendM = 1;
  endtask

  task automatic pwmRise(string tag);
    pwmIn = 1; tick;
    if (pendM) begin
      actM = bufM[trigMode == 0 ? 0 : ptrM];
      if (trigMode != 0) ptrM = (ptrM + 1 >= wrapOf(seqLen)) ? 0 : ptrM + 1;
      pendM = 0;
    end
    chkState(tag);
    pwmIn = 0; tick;
    chkState(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishUp();
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rstN = 0; pwmIn = 0; uflowIn = 0; wrEn = 0; ptrClr = 0;
    shutdownIn = 0; sdClr = 0; sensorIn = 0; trigMode = 3'd1;
    seqLen = 4'd12; wrIdx = 0; wrData = 0;
    for (int e = 0; e < 12; e++) bufM[e] = '0;
    actM = 0; ptrM = 0; pendM = 0; offM = 0;
    repeat (4) tick;
    rstN = 1; tick;
    // R1 reset state
    chkState("R1");
    check("R1", timerStart, 0, "timerStart");

    // R2 / R4 / R8 timer mode with directed patterns
    wr(0, 12'b000001_000010);
    wr(1, 12'b000010_100000);
    wr(2, 12'b110000_001111);
    wr(3, 12'b000000_111111);
    uf();
    repeat (5) tick;
    chkState("R8");            // no change before PWM rises
    pwmRise("R2");             // entry 0 loaded, pointer 1
    uf(); uf(); uf();
    pwmRise("R8");             // burst gives one transfer
    senseTo(3'b101);
    pwmRise("R4");             // sensor ignored in timer mode

    // R5 position mode
    trigMode = 3'd2;
    uf();
    pwmRise("R5");             // underflow ignored
    senseTo(3'b100);
    pwmRise("R5");

    // R6 delayed mode
    trigMode = 3'd3;
    startCnt = 0;
    senseTo(3'b110);
    check("R6", startCnt, 1, "timerStart pulses");
    pwmRise("R6");             // no transfer from sensor alone
    uf();
    pwmRise("R6");

    // R7 either source
    trigMode = 3'd4;
    startCnt = 0;
    uf();
    pwmRise("R7");
    senseTo(3'b010);
    pwmRise("R7");
    check("R7", startCnt, 0, "timerStart pulses");

    // R11 unused codes
    for (int m = 5; m < 8; m++) begin
      trigMode = 3'(m);
      uf();
      senseTo(3'(m));
      wr(0, 12'h0A5);
      pwmRise("R11");
    end

    // R3 software mode
    trigMode = 3'd0;
    wr(3, 12'h03C);
    pwmRise("R3");             // write to entry 3: nothing
    wr(0, 12'b101010_010101);
    pwmRise("R3");             // entry 0 loaded, pointer kept

    // R9 pointer wrap and clear
    trigMode = 3'd1;
    ptrClr = 1; tick; ptrClr = 0; ptrM = 0;
    chkState("R9");
    seqLen = 4'd3;
    for (int s = 0; s < 7; s++) begin uf(); pwmRise("R9"); end
    seqLen = 4'd0;
    ptrClr = 1; tick; ptrClr = 0; ptrM = 0;
    for (int s = 0; s < 13; s++) begin uf(); pwmRise("R9"); end

    // R10 emergency stop
    wr(ptrM, 12'b000000_111111);
    uf(); pwmRise("R10");
    shutdownIn = 1; #1; offM = 1;
    chkState("R10");
    tick; shutdownIn = 0; tick; tick;
    chkState("R10");           // still forced after release
    sdClr = 1; tick; sdClr = 0; offM = 0;
    chkState("R10");

    // R2 / R9 random sequences
    for (int e = 0; e < 12; e++) wr(e, 12'($urandom));
    seqLen = 4'($urandom_range(1, 12));
    ptrClr = 1; tick; ptrClr = 0; ptrM = 0;
    for (int s = 0; s < 40; s++) begin
      if (s == 20) begin
        for (int e = 0; e < 12; e++) wr(e, 12'($urandom));
        seqLen = 4'($urandom_range(1, 12));
        ptrClr = 1; tick; ptrClr = 0; ptrM = 0;
      end
      uf();
      pwmRise("R2");
    end
    finishUp();
  end
endmodule